// File: doc/BRIEF.md
# RMII 10 Mbps Frame Transmitter

This block sends Ethernet frames on a two-bit RMII transmit interface at 10 Mbps. Everything in it runs on the 50 MHz reference clock. Upstream logic supplies the frame one byte at a time, from the destination address through the last payload byte, over a valid/ready input. The transmitter builds the rest of the frame by itself:

- It sends the preamble and the start-of-frame delimiter.
- It zero-pads any frame shorter than the minimum length.
- It computes the CRC-32 frame check sequence and appends it.
- It holds the line idle for a minimum gap after each frame.

Each two-bit symbol (dibit) stays on the data pins for ten reference clocks. The CRC is computed four bits at a time from a 16-entry table, and that table is generated from the polynomial when the design elaborates. The `busy` output stays high from the first preamble dibit to the end of the gap. A new frame is taken only once `busy` is low.

Top module: `rmii_tx10`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 00 and `tx_en`, `busy` and `in_ready` are all low.
- R2: When `in_valid` is high in an idle cycle, `tx_en` and `busy` are high in the following cycle. Every dibit on `txd` is then held for DIBIT_CLKS (default 10) cycles.
- R3: A frame opens with PREAMBLE_DIBITS (default 31) dibits of value 01, followed by one dibit of value 11.
- R4: Each data byte is sent lowest dibit first, in the order bits [1:0], [3:2], [5:4], [7:6]. `in_ready` is high for exactly one cycle: the last cycle of the 11 dibit, or the last cycle of the previous byte's final dibit. A byte is taken when `in_valid` and `in_ready` are both high in that cycle.
- R5: The data ends in either of two ways. The first is that a byte accepted with `in_last` high gets no further `in_ready` pulse. The second is that `in_valid` is low during an `in_ready` pulse; that pulse then carries no byte.
- R6: When fewer than MIN_BYTES (default 60) bytes have been accepted, zero bytes are sent after the data until MIN_BYTES bytes have gone out.
- R7: After the data and the padding, 16 dibits carry the frame check sequence, least significant bit pair first. The check sequence is the CRC-32 with reflected polynomial 0xEDB88320 over the sent bytes, with the register started at all ones and the result inverted.
- R8: `tx_en` falls right after the last check-sequence dibit. `busy` then stays high, with `tx_en` low and `txd` at 00, for GAP_CLKS (default 500, which is 10 µs) cycles.
- R9: A frame starts only from idle. `in_valid` asserted during the gap has no effect on `tx_en`, on `txd` or on the gap length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream byte or frame request is present |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final byte of the frame |
| in_ready | output | 1 | One-cycle strobe: the byte on `in_data` is taken if valid |
| txd | output | 2 | RMII transmit dibit |
| tx_en | output | 1 | RMII transmit enable |
| busy | output | 1 | A frame or its trailing gap is in progress |

## Verification
The outputs `tx_en`, `busy` and `txd` change one cycle after the edge that moves the block's state. The first preamble dibit therefore appears in the cycle after `in_valid` is sampled in idle. Every later dibit changes exactly DIBIT_CLKS cycles after the one before it, and `busy` falls GAP_CLKS cycles after `tx_en` falls. The reference model expands each frame into a per-cycle list of expected `{busy, tx_en, txd}` values and compares one entry at every falling edge, starting with the cycle after the request is sampled. `in_ready` is combinational in the last cycle of a byte slot. The bench therefore reads it at the falling edge and changes `in_data` just after the next rising edge, and it counts the strobes in each frame against the number of accepted bytes.

// File: rtl/rmii_tx_pkg.sv
package rmii_tx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_PRE, PH_DATA, PH_PAD, PH_FCS, PH_GAP
  } tx_phase_e;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  // One entry of the nibble table: four reflected shift steps on the index.
  function automatic logic [31:0] crc_lut_entry(input logic [3:0] idx);
    logic [31:0] c;
    c = {28'd0, idx};
    for (int k = 0; k < 4; k++)
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
    return c;
  endfunction

  // Table index for one nibble step.
  function automatic logic [3:0] crc_nib_index(input logic [31:0] crc,
                                               input logic [3:0] nib);
    return crc[3:0] ^ nib;
  endfunction

endpackage

// File: rtl/rmii_tx_dibit_timer.sv
module rmii_tx_dibit_timer #(
  parameter int DIBIT_CLKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic dibit_end
);
  localparam int CW = (DIBIT_CLKS > 1) ? $clog2(DIBIT_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIBIT_CLKS - 1);

  logic [CW-1:0] cnt;

  assign dibit_end = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rmii_tx_crc_unit.sv
module rmii_tx_crc_unit
  import rmii_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc_q
);
  logic [31:0] lut [16];
  logic [31:0] mid, nxt;

  for (genvar g = 0; g < 16; g++) begin : g_lut
    assign lut[g] = crc_lut_entry(4'(g));
  end

  // Low nibble first, then high nibble.
  always_comb begin
    mid = lut[crc_nib_index(crc_q, din[3:0])] ^ (crc_q >> 4);
    nxt = lut[crc_nib_index(mid, din[7:4])] ^ (mid >> 4);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || init) crc_q <= '1;
    else if (en) crc_q <= nxt;
  end
endmodule

// File: rtl/rmii_tx10.sv
module rmii_tx10
  import rmii_tx_pkg::*;
#(
  parameter int DIBIT_CLKS      = 10,
  parameter int PREAMBLE_DIBITS = 31,
  parameter int MIN_BYTES       = 60,
  parameter int GAP_CLKS        = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       in_ready,
  output logic [1:0] txd,
  output logic       tx_en,
  output logic       busy
);
  localparam int DCW = (PREAMBLE_DIBITS + 1 > 16) ? $clog2(PREAMBLE_DIBITS + 1) : 4;
  localparam int BCW = $clog2(MIN_BYTES + 1);
  localparam int GCW = (GAP_CLKS > 1) ? $clog2(GAP_CLKS + 1) : 1;
  localparam logic [DCW-1:0] SFD_IDX  = DCW'(PREAMBLE_DIBITS);
  localparam logic [DCW-1:0] BYTE_END = DCW'(3);
  localparam logic [DCW-1:0] FCS_END  = DCW'(15);
  localparam logic [BCW-1:0] MIN_CNT  = BCW'(MIN_BYTES);
  localparam logic [GCW-1:0] GAP_LOAD = GCW'(GAP_CLKS - 1);

  tx_phase_e      phase;
  logic [DCW-1:0] dcnt;
  logic [31:0]    sr;
  logic [BCW-1:0] bcnt;
  logic           last_q;
  logic [GCW-1:0] gap_cnt;
  logic [31:0]    crc_q;

  // Named internal events.
  logic running, dibit_end, sfd_end, byte_end, byte_slot;
  logic take, pad_load, crc_init, crc_en;
  logic [7:0] crc_byte;

  assign running = (phase == PH_PRE) || (phase == PH_DATA) ||
                   (phase == PH_PAD) || (phase == PH_FCS);

  rmii_tx_dibit_timer #(.DIBIT_CLKS(DIBIT_CLKS)) timer_i (
    .clk(clk), .rst_n(rst_n), .run(running), .dibit_end(dibit_end)
  );

  always_comb begin
    sfd_end   = dibit_end && (phase == PH_PRE) && (dcnt == SFD_IDX);
    byte_end  = dibit_end && ((phase == PH_DATA) || (phase == PH_PAD)) &&
                (dcnt == BYTE_END);
    byte_slot = sfd_end || byte_end;
    in_ready  = sfd_end || (byte_end && (phase == PH_DATA) && !last_q);
    take      = in_ready && in_valid;
    pad_load  = byte_slot && !take && (bcnt < MIN_CNT);
    crc_init  = (phase == PH_IDLE) && in_valid;
    crc_en    = take || pad_load;
    crc_byte  = take ? in_data : 8'h00;
  end

  rmii_tx_crc_unit crc_i (
    .clk(clk), .rst_n(rst_n), .init(crc_init), .en(crc_en),
    .din(crc_byte), .crc_q(crc_q)
  );

  always_comb begin
    tx_en = running;
    busy  = (phase != PH_IDLE);
    if (phase == PH_PRE) txd = (dcnt == SFD_IDX) ? 2'b11 : 2'b01;
    else if (phase == PH_DATA || phase == PH_PAD || phase == PH_FCS) txd = sr[1:0];
    else txd = 2'b00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      dcnt    <= '0;
      sr      <= '0;
      bcnt    <= '0;
      last_q  <= 1'b0;
      gap_cnt <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (in_valid) begin
          phase  <= PH_PRE;
          dcnt   <= '0;
          bcnt   <= '0;
          last_q <= 1'b0;
        end
        PH_GAP: begin
          if (gap_cnt == '0) phase <= PH_IDLE;
          else gap_cnt <= gap_cnt - 1'b1;
        end
        default: begin
          if (byte_slot) begin
            dcnt <= '0;
            if (take) begin
              sr     <= {24'd0, in_data};
              last_q <= in_last;
              phase  <= PH_DATA;
              if (bcnt != MIN_CNT) bcnt <= bcnt + 1'b1;
            end else if (pad_load) begin
              sr    <= '0;
              phase <= PH_PAD;
              bcnt  <= bcnt + 1'b1;
            end else begin
              sr    <= ~crc_q;
              phase <= PH_FCS;
            end
          end else if (dibit_end) begin
            if (phase == PH_FCS && dcnt == FCS_END) begin
              phase   <= PH_GAP;
              gap_cnt <= GAP_LOAD;
            end else begin
              dcnt <= dcnt + 1'b1;
              sr   <= sr >> 2;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/rmii_tx10_chk.sv
module rmii_tx10_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic [1:0] txd,
  input logic       tx_en,
  input logic       busy,
  input logic       dibit_end
);
  // R1: idle line is quiet
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!tx_en && txd == 2'b00 && !in_ready));

  // R2: dibit changes only after the timer marks a slot end
  assert_dibit_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && $past(tx_en) && !$past(dibit_end)) |-> (txd == $past(txd)));

  // R4: ready strobes only at a slot end while transmitting
  assert_ready_on_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (dibit_end && tx_en));

  // R8: gap follows the end of transmission
  assert_gap_after_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en) |-> (busy && txd == 2'b00));

  // R9: a frame begins only out of idle
  assert_start_from_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> !$past(busy));
endmodule

bind rmii_tx10 rmii_tx10_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .txd(txd),
  .tx_en(tx_en), .busy(busy), .dibit_end(dibit_end)
);

// File: tb/rmii_tx10_tb_top.sv
module rmii_tx10_tb_top;
  localparam int CLK_PERIOD = 20;
  localparam int DIV = 10;
  localparam int PRE_N = 31;
  localparam int MINB = 60;
  localparam int GAP = 500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_last = 1'b0;
  logic in_ready, tx_en, busy;
  logic [1:0] txd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0] exp_q[$];   // {busy, tx_en, txd}
  int tag_q[$];           // requirement number for each expected cycle
  byte unsigned src[$];
  byte unsigned fr[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rmii_tx10 dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .txd(txd), .tx_en(tx_en), .busy(busy)
  );

  task automatic check(input bit ok, input int req, input string what,
                       input int got, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      if (errors <= 20)
        $display("FAIL R%0d %s: got %0h expected %0h", req, what, got, expv);
    end
  endtask

  // Bitwise CRC, one bit per step, independent of any table.
  function automatic logic [31:0] ref_fcs();
    logic [31:0] c = 32'hFFFFFFFF;
    foreach (fr[i])
      for (int b = 0; b < 8; b++)
        c = ((c[0] ^ fr[i][b]) == 1'b1) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    return ~c;
  endfunction

  task automatic push_dibit(input logic [1:0] d, input int req);
    for (int k = 0; k < DIV; k++) begin
      exp_q.push_back({1'b1, 1'b1, d});
      tag_q.push_back(req);
    end
  endtask

  task automatic run_frame(input int n, input bit use_last, input bit poke, input int seed);
    int idx = 0;
    int pulses = 0;
    int exp_pulses;
    logic [31:0] f;
    src.delete(); fr.delete(); exp_q.delete(); tag_q.delete();
    for (int i = 0; i < n; i++) src.push_back(8'((i * 37 + seed) & 255));
    foreach (src[i]) fr.push_back(src[i]);
    while (fr.size() < MINB) fr.push_back(8'h00);
    for (int i = 0; i < PRE_N; i++) push_dibit(2'b01, 3);     // R3 preamble
    push_dibit(2'b11, 3);                                    // R3 delimiter
    tag_q[0] = 2;                                            // R2 start cycle
    foreach (fr[i])
      for (int k = 0; k < 4; k++) push_dibit(fr[i][2*k +: 2], (i < n) ? 4 : 6); // R4, R6
    f = ref_fcs();
    for (int k = 0; k < 16; k++) push_dibit(f[2*k +: 2], 7); // R7
    for (int k = 0; k < GAP; k++) begin                      // R8 / R9 gap
      exp_q.push_back(4'b1000);
      tag_q.push_back(poke ? 9 : 8);
    end
    exp_q.push_back(4'b0000); tag_q.push_back(1);            // R1 back to idle
    exp_pulses = (use_last && n > 0) ? n : n + 1;

    in_valid = 1'b1;
    in_data  = (n > 0) ? src[0] : 8'h00;
    in_last  = use_last && (n == 1);
    @(posedge clk); #1;
    if (n == 0) in_valid = 1'b0;
    for (int i = 0; i < exp_q.size(); i++) begin
      bit take;
      logic [3:0] got;
      @(negedge clk);
      got = {busy, tx_en, txd};
      check(got === exp_q[i], tag_q[i], $sformatf("cycle %0d busy/en/txd", i),
            int'(got), int'(exp_q[i]));
      if (in_ready) pulses++;
      take = in_ready && in_valid;
      @(posedge clk); #1;
      if (take) begin
        idx++;
        if (idx < n) begin
          in_data = src[idx];
          in_last = use_last && (idx == n - 1);
        end else begin
          in_valid = 1'b0;
          in_last = 1'b0;
        end
      end
      if (poke) begin
        if (i + 1 < exp_q.size() && tag_q[i+1] == 9) begin
          in_valid = 1'b1; in_data = 8'hA5;
        end else if (tag_q[i] == 9) in_valid = 1'b0;
      end
    end
    // R4 and R5: number of ready strobes in the frame
    check(pulses == exp_pulses, 5, "ready strobe count", pulses, exp_pulses);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(!tx_en && txd == 2'b00 && !busy && !in_ready, 1, "reset outputs",
          int'({busy, tx_en, in_ready, txd}), 0);
    @(posedge clk); #1;
    run_frame(1, 1'b1, 1'b0, 3);    // R6 single byte padded
    run_frame(0, 1'b0, 1'b0, 0);    // R5 empty frame, R6 all padding
    run_frame(59, 1'b0, 1'b1, 11);  // R5 ends by dropping valid, R9 poke gap
    run_frame(60, 1'b1, 1'b0, 5);   // R6 boundary: no padding
    run_frame(61, 1'b0, 1'b1, 99);  // R4 longer than minimum, R9
    run_frame(64, 1'b1, 1'b0, 200); // R7 another data pattern
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog expired: got running expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule